// File: doc/BRIEF.md
# Reset-Guarded Memory Chip-Enable Gate

This block sits on the active-low chip-enable line between a processor and a battery-backed static RAM. A supply supervisor raises a power-fail flag while the supply is unreliable. Outside such an event the gate passes the processor's chip-enable through. During an event it keeps stray cycles from reaching the memory.

When the power-fail flag rises, the gate looks at the chip-enable at that moment:
- If the memory is idle, the gate forces the output inactive at once.
- If an access is under way, the gate holds the output active for a bounded grace window so the access can complete. It then forces the output inactive.

If the processor releases the chip-enable early, the window closes at once. Once the output has been forced inactive it stays inactive until the event ends, whatever the processor does. Both inputs cross into the block's clock through synchronizer chains. The grace window is a parameter in clock cycles; the default of 250 gives 1 µs at 250 MHz.

Top module: `ce_guard_gate`

## Requirements
- R1: While the power-fail flag (`pf_event`, active high) is low, `ce_out_n` equals `ce_in_n`, delayed by the `SYNC_STAGES` synchronizer flops (two edges by default). Chip-enables are active low: 0 selects the memory and 1 deselects it.
- R2: If the synchronized chip-enable is 1 in the cycle the synchronized flag first reads high, `ce_out_n` is 1 from the next edge to the end of the event, whatever `ce_in_n` does.
- R3: If the synchronized chip-enable is 0 in that cycle and stays 0, `ce_out_n` stays 0 for `GRACE_CYCLES` cycles after the block enters its grace state. During an event it is never low for more than `GRACE_CYCLES`+1 consecutive cycles.
- R4: When the grace window expires, `ce_out_n` goes to 1 and stays 1 until the event ends.
- R5: If the synchronized chip-enable returns to 1 during the grace window, `ce_out_n` goes to 1 in that same cycle, without waiting for the window to expire.
- R6: After `ce_out_n` has been forced to 1 within an event, driving `ce_in_n` low again neither restarts the window nor drives `ce_out_n` low.
- R7: One edge after the synchronized flag falls, the block is back in pass-through and `ce_out_n` shows the current synchronized chip-enable.
- R8: Each new event that begins with the chip-enable active gets a fresh, full-length grace window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| pf_event | input | 1 | Power-fail flag from the supervisor, active high, asynchronous |
| ce_in_n | input | 1 | Chip-enable from the processor, active low, asynchronous |
| ce_out_n | output | 1 | Guarded chip-enable to the memory, active low |

## Verification
Every input change is applied at a falling clock edge, and its effect is counted in rising edges from there:
- Pass-through shows a new `ce_in_n` level after two edges.
- A flag change shows in the block's state after three edges: two synchronizer edges and one state edge.
- The grace window ends at edge 3+`GRACE_CYCLES` after the flag is raised.
- An early release shows two edges after `ce_in_n` rises.

The bench samples at the falling edge that follows exactly that many rising edges. It also samples one edge earlier on each boundary, so that both an early and a late output change are caught. The table walk waits three edges per vector, which covers the longest settling path outside the grace window.

// File: rtl/ce_guard_gate.sv
module ce_guard_gate #(
  parameter int GRACE_CYCLES = 250,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic pf_event,
  input  logic ce_in_n,
  output logic ce_out_n
);

  localparam int CW = $clog2(GRACE_CYCLES + 1);

  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_HOLD = 2'd1,
    ST_LOCK = 2'd2
  } state_t;

  logic [SYNC_STAGES-1:0] pf_pipe;
  logic [SYNC_STAGES-1:0] ce_pipe;
  logic                   pf_s;
  logic                   ce_s;
  logic                   pf_d;
  state_t                 st, st_nx;
  logic [CW-1:0]          cnt, cnt_nx;

  always_ff @(posedge clk) begin
    pf_pipe <= {pf_pipe[SYNC_STAGES-2:0], pf_event};
    ce_pipe <= {ce_pipe[SYNC_STAGES-2:0], ce_in_n};
  end

  assign pf_s = pf_pipe[SYNC_STAGES-1];
  assign ce_s = ce_pipe[SYNC_STAGES-1];

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    if (!pf_s) begin
      st_nx  = ST_PASS;
      cnt_nx = '0;
    end else begin
      case (st)
        ST_PASS: begin
          if (!pf_d && !ce_s) begin
            st_nx  = ST_HOLD;
            cnt_nx = CW'(GRACE_CYCLES);
          end else begin
            st_nx = ST_LOCK;
          end
        end
        ST_HOLD: begin
          if (ce_s || cnt == CW'(1)) st_nx = ST_LOCK;
          else                       cnt_nx = cnt - CW'(1);
        end
        default: st_nx = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    pf_d <= pf_s;
    st   <= st_nx;
    cnt  <= cnt_nx;
  end

  assign ce_out_n = (st == ST_PASS || st == ST_HOLD) ? ce_s : 1'b1;

endmodule

module ce_guard_gate_chk #(
  parameter int GRACE_CYCLES = 250
) (
  input logic       clk,
  input logic       pf_s,
  input logic       ce_s,
  input logic [1:0] st,
  input logic       ce_out_n
);

  localparam logic [1:0] LOCKED = 2'd2;

  logic [1:0]  warm = 2'd0;
  logic [31:0] low_run;
  logic        live;

  assign live = (warm == 2'd3);

  always_ff @(posedge clk) begin
    if (warm != 2'd3) warm <= warm + 2'd1;
    if (pf_s && !ce_out_n) low_run <= low_run + 32'd1;
    else                   low_run <= 32'd0;
  end

  assert_follow_R1: assert property (@(posedge clk) disable iff (!live)
    (!pf_s && !$past(pf_s)) |-> (ce_out_n == ce_s));

  assert_onset_high_R2: assert property (@(posedge clk) disable iff (!live)
    ($rose(pf_s) && ce_s) |=> ce_out_n);

  assert_grace_bound_R3: assert property (@(posedge clk) disable iff (!live)
    pf_s |-> (low_run <= 32'(GRACE_CYCLES + 1)));

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!live)
    ($past(st) == LOCKED && pf_s) |-> (st == LOCKED));

  assert_no_reactivate_R6: assert property (@(posedge clk) disable iff (!live)
    (pf_s && $past(pf_s) && $past(ce_out_n)) |-> ce_out_n);

endmodule

bind ce_guard_gate ce_guard_gate_chk #(.GRACE_CYCLES(GRACE_CYCLES)) u_chk (
  .clk      (clk),
  .pf_s     (pf_s),
  .ce_s     (ce_s),
  .st       (st),
  .ce_out_n (ce_out_n)
);

// File: tb/ce_guard_gate_test.sv
`timescale 1ns/1ps
module ce_guard_gate_test;

  localparam int G = 20;

  logic clk = 1'b0;
  logic pf_event = 1'b1;
  logic ce_in_n = 1'b1;
  logic ce_out_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ce_guard_gate #(.GRACE_CYCLES(G), .SYNC_STAGES(2)) uut (
    .clk      (clk),
    .pf_event (pf_event),
    .ce_in_n  (ce_in_n),
    .ce_out_n (ce_out_n)
  );

  // {pf_event, ce_in_n, expected ce_out_n}
  localparam logic [2:0] VECS [0:8] = '{
    3'b011, 3'b000, 3'b011, 3'b111, 3'b101,
    3'b111, 3'b101, 3'b000, 3'b011
  };

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic exp);
    checks++;
    if (ce_out_n !== exp) begin
      errors++;
      $display("FAIL %s: ce_out_n=%b expected %b at %0t", tag, ce_out_n, exp, $time);
    end
  endtask

  initial begin
    logic prev_pf;
    @(negedge clk);
    edges(6);
    check("R2 initial event, idle memory", 1'b1);

    prev_pf = 1'b1;
    for (int i = 0; i < 9; i++) begin
      pf_event = VECS[i][2];
      ce_in_n  = VECS[i][1];
      edges(3);
      if (!VECS[i][2] && prev_pf) check("R7 table release", VECS[i][0]);
      else if (!VECS[i][2])       check("R1 table pass-through", VECS[i][0]);
      else                        check("R2 table locked", VECS[i][0]);
      prev_pf = VECS[i][2];
    end

    // R1: latency of two edges in pass-through
    ce_in_n = 1'b0;
    edges(1);
    check("R1 one edge, not yet through", 1'b1);
    edges(1);
    check("R1 two edges, through", 1'b0);

    // R3/R4: access in progress, window runs out
    edges(2);
    pf_event = 1'b1;
    edges(3);
    check("R3 grace entered", 1'b0);
    edges(G - 1);
    check("R3 last grace cycle", 1'b0);
    edges(1);
    check("R4 window expired", 1'b1);
    ce_in_n = 1'b1;
    edges(3);
    ce_in_n = 1'b0;
    edges(3);
    check("R4 stays inactive after expiry", 1'b1);

    // R7: release with chip-enable active
    pf_event = 1'b0;
    edges(2);
    check("R7 still locked before state edge", 1'b1);
    edges(1);
    check("R7 pass-through restored", 1'b0);

    // R5/R6: early release ends the window
    edges(2);
    pf_event = 1'b1;
    edges(6);
    check("R3 inside window", 1'b0);
    ce_in_n = 1'b1;
    edges(1);
    check("R5 before sync", 1'b0);
    edges(1);
    check("R5 early release", 1'b1);
    ce_in_n = 1'b0;
    edges(3);
    check("R6 re-assert ignored", 1'b1);
    edges(G + 5);
    check("R6 no restarted window", 1'b1);

    // R8: new event gets a full window
    pf_event = 1'b0;
    edges(4);
    check("R7 pass-through active", 1'b0);
    pf_event = 1'b1;
    edges(2 + G);
    check("R8 fresh window full length", 1'b0);
    edges(1);
    check("R8 fresh window expires", 1'b1);

    // R2: idle at onset, toggling ignored
    pf_event = 1'b0;
    ce_in_n  = 1'b1;
    edges(4);
    check("R1 idle pass-through", 1'b1);
    pf_event = 1'b1;
    edges(3);
    for (int k = 0; k < 6; k++) begin
      ce_in_n = ~ce_in_n;
      edges(2);
      check("R2 toggle while locked", 1'b1);
    end
    pf_event = 1'b0;
    ce_in_n  = 1'b0;
    edges(3);
    check("R7 clean return", 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule